// File: doc/BRIEF.md
# Prioritised interrupt entry sequencer

This block turns hardware event strobes into latched status flags and decides when the processor must leave its program to service one of them. A source is eligible when its flag and its own enable are both 1 and the shared mask bit is 0. The block picks the eligible source with the lowest index. It starts the entry sequence only in a cycle where the processor reports that an instruction has just finished.

The entry sequence has three phases in a fixed order. The first is a register-save phase. Next comes a single vector cycle: the mask bit is already 1 there, and the block presents the handler address of the chosen source. Last is an instruction-prefetch phase. Software clears a flag by writing a 1 to that flag's bit on the clear port. A return-from-interrupt strobe loads the mask bit from the saved value it carries. A separate strobe lets software clear the mask bit, which allows nested service.

Top module: `irq_seq`

## Requirements
- R1: After reset all flags are 0, the mask bit is 1, and busy and all phase outputs are 0.
- R2: An event pulse on bit i sets flags[i] from the next cycle on, whatever enables[i] holds. The flag stays set until a cycle where clear bit i is 1. If an event and a clear hit the same bit in the same cycle, the flag stays set.
- R3: A source can start an entry only if flags[i], enables[i] and an inverted mask bit are all 1. With the mask at 1, or with no enabled flag set, no entry starts.
- R4: An entry starts only in a cycle where the instruction-boundary strobe is 1 and the block is idle. The save phase begins in the next cycle.
- R5: The save phase lasts exactly 5 cycles, the vector phase 1 cycle and the prefetch phase 3 cycles. At most one phase output is high at a time, and busy is high in all 9 cycles.
- R6: The mask bit becomes 1 in the vector cycle and stays 1 until a mask-clear strobe or a return strobe.
- R7: The lowest-index pending source wins. The vector address is 16'hFFFE minus twice that index, and vec_src shows the index. Both hold from the vector cycle until the next entry.
- R8: The source is chosen again, from the flags of that moment, when the vector phase starts. A flag that is set during the save phase can therefore win. A flag set in or after the vector cycle waits for a later entry.
- R9: A return strobe loads the mask with ret_mask. A mask-clear strobe sets the mask to 0. With the mask at 0 inside a handler, a pending source starts a new entry at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | N | Event strobes, one per source |
| enables | input | N | Per-source enable bits |
| flag_clr | input | N | Write 1 to clear the matching flag |
| boundary | input | 1 | Instruction-boundary strobe |
| mask_clr | input | 1 | Software strobe that clears the mask bit |
| ret | input | 1 | Return-from-interrupt strobe |
| ret_mask | input | 1 | Saved mask value carried by the return strobe |
| flags | output | N | Status flags |
| mask | output | 1 | Current mask bit |
| busy | output | 1 | High for the whole entry sequence |
| saving | output | 1 | Register-save phase |
| vec_phase | output | 1 | Vector-fetch cycle |
| prefetch | output | 1 | Prefetch phase |
| vec_src | output | $clog2(N) | Chosen source index |
| vec_addr | output | 16 | Handler vector address |

## Verification
Two things can land in the same cycle. The first is an event and a clear on one flag bit. The bench provokes it with a directed overlap and judges it against a model in which the event wins. The second is a new higher-priority event during an entry that is already under way. The bench injects that event once during the save phase and once in the vector cycle. Its priority function predicts the re-chosen source in the first case and the unchanged source in the second. Random event and clear traffic between entries keeps the flag model checked every cycle.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int N = 8,
  parameter int AW = 16,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  parameter int SAVE_LEN = 5,
  parameter int FILL_LEN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         evt,
  input  logic [N-1:0]         enables,
  input  logic [N-1:0]         flag_clr,
  input  logic                 boundary,
  input  logic                 mask_clr,
  input  logic                 ret,
  input  logic                 ret_mask,
  output logic [N-1:0]         flags,
  output logic                 mask,
  output logic                 busy,
  output logic                 saving,
  output logic                 vec_phase,
  output logic                 prefetch,
  output logic [$clog2(N)-1:0] vec_src,
  output logic [AW-1:0]        vec_addr
);
  localparam int SW = $clog2(N);
  localparam int LMAX = (SAVE_LEN > FILL_LEN) ? SAVE_LEN : FILL_LEN;
  localparam int CW = $clog2(LMAX + 1);

  typedef enum logic [1:0] {IDLE, SAVE, VEC, FILL} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [N-1:0] pend;
  logic take, save_end, fill_end;

  function automatic logic [SW-1:0] lowest(input logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) lowest = SW'(i);
  endfunction

  assign pend     = flags & enables;
  assign take     = (st == IDLE) && boundary && !mask && (|pend);
  assign save_end = (st == SAVE) && (cnt == CW'(SAVE_LEN - 1));
  assign fill_end = (st == FILL) && (cnt == CW'(FILL_LEN - 1));
  assign busy      = (st != IDLE);
  assign saving    = (st == SAVE);
  assign vec_phase = (st == VEC);
  assign prefetch  = (st == FILL);
  assign vec_addr  = VEC_TOP[AW-1:0] - AW'({vec_src, 1'b0});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: if (take) begin st <= SAVE; cnt <= '0; end
        SAVE: if (save_end) st <= VEC; else cnt <= cnt + 1'b1;
        VEC:  begin st <= FILL; cnt <= '0; end
        FILL: if (fill_end) st <= IDLE; else cnt <= cnt + 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vec_src <= '0;
    else if (take || (save_end && |pend)) vec_src <= lowest(pend);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        mask <= 1'b1;
    else if (save_end) mask <= 1'b1;
    else if (ret)      mask <= ret_mask;
    else if (mask_clr) mask <= 1'b0;

  a_r4_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary && !mask));
  a_r3_start_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(|(flags & enables)));
  a_r5_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({saving, vec_phase, prefetch}) && (busy == (saving | vec_phase | prefetch)));
  a_r5_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_phase |=> prefetch);
  a_r6_masked_at_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_phase |-> mask);
  a_r7_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch |-> $stable(vec_addr));
  a_r2_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  logic clk = 0, rst_n = 0;
  logic [7:0] evt = 0, enables = 0, flag_clr = 0;
  logic boundary = 0, mask_clr = 0, ret = 0, ret_mask = 0;
  logic [7:0] flags;
  logic mask, busy, saving, vec_phase, prefetch;
  logic [2:0] vec_src;
  logic [15:0] vec_addr;
  logic [7:0] mflags = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_seq u0 (.clk(clk), .rst_n(rst_n), .evt(evt), .enables(enables), .flag_clr(flag_clr),
    .boundary(boundary), .mask_clr(mask_clr), .ret(ret), .ret_mask(ret_mask), .flags(flags),
    .mask(mask), .busy(busy), .saving(saving), .vec_phase(vec_phase), .prefetch(prefetch),
    .vec_src(vec_src), .vec_addr(vec_addr));

  function automatic int pick(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction
  function automatic logic [15:0] vaddr(input int s);
    return 16'hFFFE - 16'(2 * s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    mflags = (mflags & ~flag_clr) | evt;
    @(negedge clk);
    evt = 0; flag_clr = 0; boundary = 0; mask_clr = 0; ret = 0;
  endtask

  task automatic entry(input int inj_k, input logic [7:0] inj);
    int es = 0;
    boundary = 1;
    tick();
    for (int k = 1; k <= 10; k++) begin
      chk("R5 saving", saving, k <= 5);
      chk("R5 vec_phase", vec_phase, k == 6);
      chk("R5 prefetch", prefetch, k >= 7 && k <= 9);
      chk("R5 busy", busy, k <= 9);
      if (k == 5) es = pick(mflags & enables);
      if (k == 6) begin
        chk("R6 mask at vector", mask, 1);
        chk("R7 R8 vec_src", vec_src, es);
        chk("R7 vec_addr", vec_addr, vaddr(es));
      end
      if (k == 9) chk("R7 vec held", vec_addr, vaddr(es));
      if (k == inj_k) evt = inj;
      if (k < 10) tick();
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    @(negedge clk); @(negedge clk);
    chk("R1 flags", flags, 0); chk("R1 mask", mask, 1); chk("R1 busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 phases", {saving, vec_phase, prefetch}, 0);

    for (int c = 0; c < 300; c++) begin
      evt = 8'($urandom) & 8'($urandom);
      flag_clr = 8'($urandom) & 8'($urandom);
      enables = 8'($urandom);
      boundary = $urandom % 2;
      tick();
      chk("R2 flags model", flags, mflags);
      chk("R3 masked no entry", busy, 0);
    end

    flag_clr = 8'hFF; tick();
    evt = 8'h10; flag_clr = 8'h10; tick();
    chk("R2 event beats clear", flags[4], 1);
    flag_clr = 8'h10; tick();
    chk("R2 clear", flags[4], 0);

    mask_clr = 1; tick();
    chk("R9 mask clear", mask, 0);
    enables = 8'h00; evt = 8'h08; tick();
    chk("R2 flag without enable", flags[3], 1);
    boundary = 1; tick();
    chk("R3 disabled no entry", busy, 0);
    enables = 8'hFF; evt = 8'h40; tick(); tick();
    chk("R4 no boundary no entry", busy, 0);

    entry(3, 8'h02);
    chk("R6 mask after entry", mask, 1);
    flag_clr = 8'h02; tick();
    boundary = 1; tick();
    chk("R3 masked pending no entry", busy, 0);
    ret = 1; ret_mask = 0; tick();
    chk("R9 return loads 0", mask, 0);
    entry(6, 8'h01);
    chk("R8 late source kept pending", flags[0], 1);

    mask_clr = 1; tick();
    entry(0, 8'h00);
    chk("R9 nested entry src", vec_src, 0);
    ret = 1; ret_mask = 1; tick();
    chk("R9 return loads 1", mask, 1);

    for (int r = 0; r < 20; r++) begin
      flag_clr = 8'hFF; tick();
      evt = 8'($urandom) | 8'h80;
      enables = 8'($urandom) | 8'h80;
      mask_clr = 1; tick();
      entry(0, 8'h00);
      chk("R2 R6 flags after entry", flags, mflags);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule